// File: doc/BRIEF.md
# Byte Buffer with Water-Level Alerts

This block is a byte-wide first-in first-out store of 64 entries. It sits between a host register port and an internal protocol engine. The host reaches the store through a small register window with four addresses. Reading or writing the data address pops or pushes one byte. The engine pushes and pops through its own strobes.

From the occupancy the block derives two warnings against a programmable water level: one when the store is close to full and one when it is close to empty. It also keeps a sticky overflow error. Each warning sets an interrupt request bit on its rising edge, and software clears that bit by writing a one to it. A flush, requested through the level address, empties the store in a single cycle and is the only way to clear the overflow error.

Top module: `byte_fifo_alert`

## Requirements
- R1: After reset the level reads 0, the water level reads 8, the status reads 01h (near-empty set, near-full, overflow and both requests clear), and both request pins are low.
- R2: Bytes written to address 0 or pushed by the engine leave in the same order, whether they are read at address 0 or popped by the engine. When the host and the engine push in the same cycle, only the engine byte is stored.
- R3: Reading address 1 returns the stored byte count in bits [6:0], and bit 7 always reads 0.
- R4: Writing address 1 with bit 7 set empties the store in one cycle and clears the overflow error. A push in the same cycle is dropped. Writing address 1 with bit 7 clear changes nothing.
- R5: A push into a full store without a pop in the same cycle is discarded, and it sets the overflow error (status bit 2). A push and a pop together on a full store are both accepted, and the overflow error stays clear.
- R6: Pops and writes to the status address never clear the overflow error.
- R7: A pop from an empty store returns 00h and leaves the level at 0.
- R8: The water level is held in bits [5:0] of address 2. Near-full (status bit 1) is high when 64 minus the level is at or below the water level. Near-empty (status bit 0) is high when the level is at or below the water level.
- R9: A 0-to-1 change of near-empty sets the empty request (status bit 4, pin irq_lo). A 0-to-1 change of near-full sets the full request (status bit 5, pin irq_hi). Writing 1 to bit 4 or bit 5 of address 3 clears that request. If a set and a clear of the same request fall in the same cycle, the set wins.
- R10: A push and a pop accepted in the same cycle leave the level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_re | input | 1 | Host register read strobe (a read of address 0 pops) |
| host_addr | input | 2 | Host register address: 0 data, 1 level/flush, 2 water level, 3 status/requests |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid in the cycle of the read |
| eng_push | input | 1 | Engine push strobe |
| eng_wdata | input | 8 | Engine push byte |
| eng_pop | input | 1 | Engine pop strobe |
| eng_rdata | output | 8 | Head byte (00h when empty), consumed by eng_pop |
| alert_lo | output | 1 | Near-empty warning |
| alert_hi | output | 1 | Near-full warning |
| overflow | output | 1 | Sticky overflow error |
| irq_lo | output | 1 | Near-empty interrupt request |
| irq_hi | output | 1 | Near-full interrupt request |

## Verification
Several pairs of functions can land in the same cycle. The bench drives these collisions on purpose.

- Push and pop together: an engine push is driven alongside a host data read, once on a partly filled store and once on a full store. The level must not move, and no overflow may be raised.
- Flush and push together: a flush write is issued in the same cycle as an engine push. The store must come out empty.
- Request set and software clear together: an engine pop drops the level onto the water level, and the bench times a clear write to the cycle in which the request is set. The request must survive that write, and a later clear must remove it.

// File: rtl/bfa_pkg.sv
// Package: shared register addresses and field positions of the byte buffer.
// Assumes a two-bit host address and an eight-bit host data path.
package bfa_pkg;

    typedef enum logic [1:0] {
        REG_DATA  = 2'd0,
        REG_LEVEL = 2'd1,
        REG_WATER = 2'd2,
        REG_STAT  = 2'd3
    } reg_sel_e;

    localparam int unsigned HOST_DW     = 8;
    localparam int unsigned FLUSH_BIT   = 7;
    localparam int unsigned ST_LO_BIT   = 0;
    localparam int unsigned ST_HI_BIT   = 1;
    localparam int unsigned ST_OVF_BIT  = 2;
    localparam int unsigned ST_IRQL_BIT = 4;
    localparam int unsigned ST_IRQH_BIT = 5;

endpackage

// File: rtl/bfa_store.sv
// Module: storage array, read/write pointers, occupancy count and sticky overflow.
// Assumes: flush outranks push and pop; a push into a full store is accepted
// only when a pop is accepted in the same cycle; a pop from empty does nothing.
module bfa_store #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned DW    = 8,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [DW-1:0]    push_data,
    input  logic             pop,
    input  logic             flush,
    output logic [DW-1:0]    head_data,
    output logic [LVL_W-1:0] level,
    output logic             overflow
);

    logic [DW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [LVL_W-1:0] count;
    logic             full, empty, do_push, do_pop;

    assign full     = (count == LVL_W'(DEPTH));
    assign empty    = (count == '0);
    assign do_pop   = pop & ~empty & ~flush;
    assign do_push  = push & ~flush & (~full | do_pop);
    assign level    = count;
    assign head_data = empty ? '0 : mem[rd_ptr];

    // Store accepted bytes at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // Advance pointers and the count; flush returns all to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Sticky overflow: set by a discarded push, cleared only by flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush)                   overflow <= 1'b0;
        else if (push && full && !do_pop)      overflow <= 1'b1;
    end

    assert_level_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        count <= LVL_W'(DEPTH));
    assert_full_push_ovf_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> overflow);
    assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(overflow) |-> $past(flush));
    assert_flush_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (level == '0));
    assert_empty_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !flush) |=> (level == '0));
    assert_pushpop_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !empty && !flush) |=> (level == $past(level)));

endmodule

// File: rtl/bfa_alert.sv
// Module: near-full / near-empty comparators and edge-set interrupt requests.
// Assumes: level never exceeds DEPTH; a set of a request outranks its clear.
module bfa_alert #(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned LVL_W = $clog2(DEPTH + 1),
    localparam int unsigned WL_W  = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] level,
    input  logic [WL_W-1:0]  water,
    input  logic             clr_lo,
    input  logic             clr_hi,
    output logic             alert_lo,
    output logic             alert_hi,
    output logic             irq_lo,
    output logic             irq_hi
);

    logic [LVL_W:0] free_cnt;
    logic           prev_lo, prev_hi;

    assign free_cnt = (LVL_W + 1)'(DEPTH) - {1'b0, level};
    assign alert_hi = (free_cnt <= (LVL_W + 1)'(water));
    assign alert_lo = ({1'b0, level} <= (LVL_W + 1)'(water));

    // Remember last cycle's warnings for edge detection (empty-store values at reset).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_lo <= 1'b1;
            prev_hi <= 1'b0;
        end else begin
            prev_lo <= alert_lo;
            prev_hi <= alert_hi;
        end
    end

    // Requests: set on a rising warning, cleared by software write-one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_lo <= 1'b0;
            irq_hi <= 1'b0;
        end else begin
            if (alert_lo && !prev_lo) irq_lo <= 1'b1;
            else if (clr_lo)          irq_lo <= 1'b0;
            if (alert_hi && !prev_hi) irq_hi <= 1'b1;
            else if (clr_hi)          irq_hi <= 1'b0;
        end
    end

    assert_irq_hi_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_hi) |-> $past(alert_hi));
    assert_irq_lo_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_lo) |-> $past(alert_lo));
    assert_irq_lo_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_lo) |-> $past(clr_lo));
    assert_irq_hi_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_hi) |-> $past(clr_hi));

endmodule

// File: rtl/bfa_regport.sv
// Module: host register window decode, water-level register and read mux.
// Assumes: one host access per cycle; data reads are combinational and pop at the edge.
module bfa_regport
    import bfa_pkg::*;
#(
    parameter int unsigned DEPTH    = 64,
    parameter int unsigned WL_RESET = 8,
    localparam int unsigned LVL_W = $clog2(DEPTH + 1),
    localparam int unsigned WL_W  = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_we,
    input  logic               host_re,
    input  logic [1:0]         host_addr,
    input  logic [HOST_DW-1:0] host_wdata,
    output logic [HOST_DW-1:0] host_rdata,
    input  logic [HOST_DW-1:0] head_data,
    input  logic [LVL_W-1:0]   level,
    input  logic               alert_lo,
    input  logic               alert_hi,
    input  logic               overflow,
    input  logic               irq_lo,
    input  logic               irq_hi,
    output logic               host_push,
    output logic               host_pop,
    output logic               flush,
    output logic               clr_lo,
    output logic               clr_hi,
    output logic [WL_W-1:0]    water
);

    reg_sel_e sel;
    assign sel = reg_sel_e'(host_addr);

    assign host_push = host_we & (sel == REG_DATA);
    assign host_pop  = host_re & (sel == REG_DATA);
    assign flush     = host_we & (sel == REG_LEVEL) & host_wdata[FLUSH_BIT];
    assign clr_lo    = host_we & (sel == REG_STAT) & host_wdata[ST_IRQL_BIT];
    assign clr_hi    = host_we & (sel == REG_STAT) & host_wdata[ST_IRQH_BIT];

    // Water-level register.
    always_ff @(posedge clk) begin
        if (!rst_n)                              water <= WL_W'(WL_RESET);
        else if (host_we && sel == REG_WATER)    water <= host_wdata[WL_W-1:0];
    end

    // Read-back mux; the flush bit and unused bits read as zero.
    always_comb begin
        host_rdata = '0;
        case (sel)
            REG_DATA:  host_rdata = head_data;
            REG_LEVEL: host_rdata[FLUSH_BIT-1:0] = (FLUSH_BIT)'(level);
            REG_WATER: host_rdata = HOST_DW'(water);
            REG_STAT: begin
                host_rdata[ST_LO_BIT]   = alert_lo;
                host_rdata[ST_HI_BIT]   = alert_hi;
                host_rdata[ST_OVF_BIT]  = overflow;
                host_rdata[ST_IRQL_BIT] = irq_lo;
                host_rdata[ST_IRQH_BIT] = irq_hi;
            end
            default:   host_rdata = '0;
        endcase
    end

endmodule

// File: rtl/byte_fifo_alert.sv
// Module: top of the byte buffer; merges host and engine strobes.
// Assumes: engine push byte wins over a host push in the same cycle;
// simultaneous host and engine pops consume a single byte.
module byte_fifo_alert
    import bfa_pkg::*;
#(
    parameter int unsigned DEPTH    = 64,
    parameter int unsigned WL_RESET = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_we,
    input  logic       host_re,
    input  logic [1:0] host_addr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    input  logic       eng_push,
    input  logic [7:0] eng_wdata,
    input  logic       eng_pop,
    output logic [7:0] eng_rdata,
    output logic       alert_lo,
    output logic       alert_hi,
    output logic       overflow,
    output logic       irq_lo,
    output logic       irq_hi
);

    localparam int unsigned LVL_W = $clog2(DEPTH + 1);
    localparam int unsigned WL_W  = $clog2(DEPTH);

    logic             host_push, host_pop, flush, clr_lo, clr_hi;
    logic [WL_W-1:0]  water;
    logic [LVL_W-1:0] level;
    logic [7:0]       head_data, push_data;
    logic             push, pop;

    assign push      = eng_push | host_push;
    assign push_data = eng_push ? eng_wdata : host_wdata;
    assign pop       = eng_pop | host_pop;
    assign eng_rdata = head_data;

    bfa_regport #(.DEPTH(DEPTH), .WL_RESET(WL_RESET)) u_regport (
        .clk(clk), .rst_n(rst_n),
        .host_we(host_we), .host_re(host_re), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .head_data(head_data), .level(level),
        .alert_lo(alert_lo), .alert_hi(alert_hi), .overflow(overflow),
        .irq_lo(irq_lo), .irq_hi(irq_hi),
        .host_push(host_push), .host_pop(host_pop), .flush(flush),
        .clr_lo(clr_lo), .clr_hi(clr_hi), .water(water)
    );

    bfa_store #(.DEPTH(DEPTH), .DW(8)) u_store (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_data(push_data), .pop(pop), .flush(flush),
        .head_data(head_data), .level(level), .overflow(overflow)
    );

    bfa_alert #(.DEPTH(DEPTH)) u_alert (
        .clk(clk), .rst_n(rst_n),
        .level(level), .water(water), .clr_lo(clr_lo), .clr_hi(clr_hi),
        .alert_lo(alert_lo), .alert_hi(alert_hi),
        .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

endmodule

// File: tb/byte_fifo_alert_tb.sv
// Directed bench: one task per scenario; tasks are entered at a falling edge.
module byte_fifo_alert_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_we = 1'b0, host_re = 1'b0;
    logic [1:0] host_addr = 2'd0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       eng_push = 1'b0, eng_pop = 1'b0;
    logic [7:0] eng_wdata = 8'h00;
    logic [7:0] eng_rdata;
    logic       alert_lo, alert_hi, overflow, irq_lo, irq_hi;

    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    byte_fifo_alert u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_we(host_we), .host_re(host_re), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .eng_push(eng_push), .eng_wdata(eng_wdata), .eng_pop(eng_pop),
        .eng_rdata(eng_rdata), .alert_lo(alert_lo), .alert_hi(alert_hi),
        .overflow(overflow), .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [1:0] a, input logic [7:0] d);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic hread(input logic [1:0] a, output logic [7:0] d);
        host_re = 1'b1; host_addr = a;
        #1 d = host_rdata;
        @(negedge clk);
        host_re = 1'b0;
    endtask

    task automatic epush(input logic [7:0] d);
        eng_push = 1'b1; eng_wdata = d;
        @(negedge clk);
        eng_push = 1'b0;
    endtask

    task automatic epop(output logic [7:0] d);
        eng_pop = 1'b1;
        #1 d = eng_rdata;
        @(negedge clk);
        eng_pop = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        hread(2'd1, v); check("R1 level", v, 8'h00);
        hread(2'd2, v); check("R1 water", v, 8'h08);
        hread(2'd3, v); check("R1 status", v, 8'h01);
        check("R1 irq pins", {6'd0, irq_hi, irq_lo}, 8'h00);
    endtask

    task automatic t_order();
        logic [7:0] v;
        hwrite(2'd0, 8'h11); hwrite(2'd0, 8'h22); epush(8'h33);
        hread(2'd1, v); check("R3 level", v, 8'h03);
        hread(2'd0, v); check("R2 first", v, 8'h11);
        epop(v);        check("R2 second", v, 8'h22);
        hread(2'd0, v); check("R2 third", v, 8'h33);
        // engine and host push together: engine byte only
        host_we = 1'b1; host_addr = 2'd0; host_wdata = 8'hAA;
        eng_push = 1'b1; eng_wdata = 8'h55;
        @(negedge clk);
        host_we = 1'b0; eng_push = 1'b0;
        hread(2'd1, v); check("R2 dual push level", v, 8'h01);
        hread(2'd0, v); check("R2 dual push byte", v, 8'h55);
    endtask

    task automatic t_empty_pop();
        logic [7:0] v;
        hread(2'd0, v); check("R7 empty data", v, 8'h00);
        hread(2'd1, v); check("R7 empty level", v, 8'h00);
    endtask

    task automatic t_pushpop();
        logic [7:0] v;
        epush(8'h01); epush(8'h02); epush(8'h03);
        eng_push = 1'b1; eng_wdata = 8'h04; host_re = 1'b1; host_addr = 2'd0;
        #1 v = host_rdata;
        @(negedge clk);
        eng_push = 1'b0; host_re = 1'b0;
        check("R10 head byte", v, 8'h01);
        hread(2'd1, v); check("R10 level kept", v, 8'h03);
    endtask

    task automatic t_flush();
        logic [7:0] v;
        hwrite(2'd1, 8'h7F);
        hread(2'd1, v); check("R4 no-flush write", v, 8'h03);
        hwrite(2'd1, 8'h80);
        hread(2'd1, v); check("R4 flushed level", v, 8'h00);
        epush(8'h44);
        host_we = 1'b1; host_addr = 2'd1; host_wdata = 8'h80;
        eng_push = 1'b1; eng_wdata = 8'h99;
        @(negedge clk);
        host_we = 1'b0; eng_push = 1'b0;
        hread(2'd1, v); check("R4 flush beats push", v, 8'h00);
        epush(8'h66);
        hread(2'd0, v); check("R4 fresh byte after flush", v, 8'h66);
    endtask

    task automatic t_overflow();
        logic [7:0] v;
        for (int i = 0; i < 64; i++) epush(8'(i));
        hread(2'd1, v); check("R3 full level", v, 8'h40);
        hread(2'd3, v); check("R8 full status", v & 8'h07, 8'h02);
        eng_push = 1'b1; eng_wdata = 8'hFE; host_re = 1'b1; host_addr = 2'd0;
        #1 v = host_rdata;
        @(negedge clk);
        eng_push = 1'b0; host_re = 1'b0;
        check("R5 pop at full head", v, 8'h00);
        hread(2'd3, v); check("R5 no ovf on push+pop", v & 8'h04, 8'h00);
        hread(2'd1, v); check("R10 full level kept", v, 8'h40);
        epush(8'hEE);
        hread(2'd3, v); check("R5 ovf set", v & 8'h04, 8'h04);
        hread(2'd1, v); check("R5 level stays 64", v, 8'h40);
        hread(2'd0, v); check("R5 overflow byte dropped, head", v, 8'h01);
        hread(2'd3, v); check("R6 ovf after pop", v & 8'h04, 8'h04);
        hwrite(2'd3, 8'hFF);
        hread(2'd3, v); check("R6 ovf after status write", v & 8'h04, 8'h04);
        check("R6 ovf pin", {7'd0, overflow}, 8'h01);
        hwrite(2'd1, 8'h80);
        hread(2'd3, v); check("R4 flush clears ovf", v & 8'h04, 8'h00);
    endtask

    task automatic t_irq();
        logic [7:0] v;
        idle();
        hwrite(2'd3, 8'h30);
        hread(2'd3, v); check("R9 cleared", v, 8'h01);
        for (int i = 0; i < 9; i++) epush(8'h20);
        hread(2'd3, v); check("R8 lo off at 9", v, 8'h00);
        epop(v); idle();
        hread(2'd3, v); check("R9 lo request set", v, 8'h11);
        check("R9 irq_lo pin", {7'd0, irq_lo}, 8'h01);
        hwrite(2'd3, 8'h10);
        hread(2'd3, v); check("R9 lo request cleared", v, 8'h01);
        epush(8'h21); idle();
        // pop drops level to 8 at edge 1; clear write meets the set at edge 2
        eng_pop = 1'b1;
        @(negedge clk);
        eng_pop = 1'b0;
        hwrite(2'd3, 8'h10);
        hread(2'd3, v); check("R9 set beats clear", v & 8'h10, 8'h10);
        hwrite(2'd3, 8'h10);
        hread(2'd3, v); check("R9 later clear", v & 8'h10, 8'h00);
        for (int i = 0; i < 47; i++) epush(8'h30);
        hread(2'd3, v); check("R8 hi off at 55", v & 8'h02, 8'h00);
        epush(8'h31); idle();
        hread(2'd3, v); check("R8 hi on at 56", v & 8'h02, 8'h02);
        check("R9 irq_hi pin", {7'd0, irq_hi}, 8'h01);
        hwrite(2'd3, 8'h20);
        check("R9 irq_hi cleared", {7'd0, irq_hi}, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_order();
        t_empty_pop();
        t_pushpop();
        t_flush();
        t_overflow();
        t_irq();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule